// File: doc/BRIEF.md
# Shared-Memory Autoload Timer Pool

This block keeps a pool of sixteen 16-bit autoload timers that count upward. It does not give each timer its own counter. A single sequencing engine keeps every timer's current count and reload value in a small byte-wide storage array, 64 bytes in all (four bytes per timer). A prescaler with a host-programmed period sends the engine a periodic tick. On each tick the engine sweeps all timers in index order. For each timer it does a read-modify-write on the count, low byte first and then high byte with the carry. When a count passes 0xFFFF, the engine copies the reload value back into the count and raises that timer's overflow flag.

The host register block drives a command port that can load a timer's reload value or start the timer. Starting a timer also loads its count, clears its overflow flag and sets its gate flag. Commands and the sweep share the one storage write port. The engine only switches between them at timer boundaries, so a command never splits the low-byte and high-byte update of a timer. A command waits at most for the timer currently in progress. The gate flag only qualifies interrupt reporting outside this block, and counting never depends on it. A read port returns any timer's current count.

Top module: `tpool_top`

## Requirements
- R1: After reset every count, every reload value, every overflow flag and every gate flag is zero, and the prescaler produces no tick until a nonzero period is written.
- R2: A write of period P (P > 0) on `pre_wr` makes `tick_o` pulse for one cycle every P clocks, the first pulse coming P clocks after the write. Writing 0 stops the ticks.
- R3: Each tick adds one to every timer's count. The low byte is updated first and a carry passes into the high byte, so 0x00FF becomes 0x0100.
- R4: A count of 0xFFFF that receives a tick is replaced by the timer's reload value, and the timer's overflow flag (bit i of `ovf_flags` for timer i) is set.
- R5: Timers keep counting on every tick whatever the state of their gate flag.
- R6: A command with `cmd_start`=1 sets the selected timer's reload value and count to `cmd_init`, clears its overflow flag and sets its gate flag (bit i of `gate_flags`). A command with `cmd_start`=0 changes only the reload value and leaves the count and flags alone.
- R7: A command accepted in the middle of a sweep leaves its target at `cmd_init` or `cmd_init`+1. Every other timer receives exactly one increment from that sweep.
- R8: `cmd_busy` rises in the cycle after a command is accepted (`cmd_valid` while `cmd_busy` is low). It stays high until the command is stored: 5 cycles for a start and 3 for a load-only command when no sweep is in progress, and never more than 10. A `cmd_valid` seen while `cmd_busy` is high is ignored.
- R9: A tick that arrives while a sweep is running is held pending and starts another full sweep when the current one ends. Every tick produces exactly one increment of every timer.
- R10: A one-cycle pulse on bit i of `ovf_clr` or `gate_clr` clears the matching flag. When the engine sets an overflow flag in the same cycle as the clear, the set wins.
- R11: `rd_count` returns the current count of the timer selected by `rd_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_wr | input | 1 | Strobe that writes the prescaler period |
| pre_period | input | 16 | Prescaler period in clocks, 0 disables |
| cmd_valid | input | 1 | Command request |
| cmd_sel | input | 4 | Target timer of the command |
| cmd_start | input | 1 | 1: start (load count, clear overflow, set gate); 0: load reload only |
| cmd_init | input | 16 | Initial count / reload value |
| cmd_busy | output | 1 | Command accepted and not yet stored |
| ovf_clr | input | 16 | Per-timer overflow flag clear pulses |
| gate_clr | input | 16 | Per-timer gate flag clear pulses |
| ovf_flags | output | 16 | Overflow flags |
| gate_flags | output | 16 | Gate flags |
| rd_sel | input | 4 | Timer selected for count read |
| rd_count | output | 16 | Count of the selected timer |
| tick_o | output | 1 | Prescaler tick pulse |
| sweeping | output | 1 | Sweep running or tick pending |

## Verification
The bench builds the block with its defaults: sixteen timers and a 16-bit prescaler. The full index range is exercised, including the last timer, where the sweep index wraps back to zero. Prescaler periods of 7 and 30 clocks are shorter than a 16-timer sweep, which takes 48 to 80 cycles. These periods make a tick arrive mid-sweep, so the pending-tick path is reached. The longer random periods still leave a tick pending behind a sweep that is full of reloads. Commands are injected at random offsets inside a sweep, so they land both before and after their target has been visited.

// File: rtl/tpool_pkg.sv
package tpool_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  // byte slot inside each timer's four-byte record
  localparam logic [1:0] SLOT_CNT_LO = 2'd0;
  localparam logic [1:0] SLOT_CNT_HI = 2'd1;
  localparam logic [1:0] SLOT_RLD_LO = 2'd2;
  localparam logic [1:0] SLOT_RLD_HI = 2'd3;

  typedef enum logic [3:0] {
    ST_ARB,    // boundary: choose command, sweep step or idle
    ST_INC_LO, // count low byte + 1
    ST_INC_HI, // count high byte + carry
    ST_RLD_LO, // copy reload low into count
    ST_RLD_HI, // copy reload high into count
    ST_CMD_0,  // write reload low
    ST_CMD_1,  // write reload high
    ST_CMD_2,  // write count low
    ST_CMD_3   // write count high, update flags
  } eng_state_e;

endpackage

// File: rtl/tpool_store.sv
module tpool_store #(
  parameter int NUM_TMR = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [$clog2(NUM_TMR)+1:0]        waddr,
  input  logic [tpool_pkg::BYTE_W-1:0]      wdata,
  input  logic [$clog2(NUM_TMR)+1:0]        eng_raddr,
  output logic [tpool_pkg::BYTE_W-1:0]      eng_rdata,
  input  logic [$clog2(NUM_TMR)-1:0]        host_sel,
  output logic [tpool_pkg::CNT_W-1:0]       host_count
);
  import tpool_pkg::*;

  localparam int ID_W  = $clog2(NUM_TMR);
  localparam int DEPTH = NUM_TMR * 4;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit;
    assign hit = we && (waddr == (ID_W+2)'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign eng_rdata  = mem_q[eng_raddr];
  assign host_count = {mem_q[{host_sel, SLOT_CNT_HI}], mem_q[{host_sel, SLOT_CNT_LO}]};

endmodule

// File: rtl/tpool_prescaler.sv
module tpool_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PRE_W-1:0] wr_period,
  output logic             tick
);

  logic [PRE_W-1:0] per_q, per_d;
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    per_d  = per_q;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (wr_en) begin
      per_d = wr_period;
      cnt_d = '0;
    end else if (per_q == '0) begin
      cnt_d = '0;
    end else if (cnt_q == per_q - 1'b1) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2: a tick only ever comes out of an enabled prescaler
  p_tick_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ($past(per_q) != '0));

  // R2: after a period write the next cycle carries no tick
  p_wr_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick_q);

endmodule

// File: rtl/tpool_engine.sv
module tpool_engine #(
  parameter int NUM_TMR = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          cmd_valid,
  input  logic [$clog2(NUM_TMR)-1:0]    cmd_sel,
  input  logic                          cmd_start,
  input  logic [tpool_pkg::CNT_W-1:0]   cmd_init,
  output logic                          cmd_busy,
  input  logic [NUM_TMR-1:0]            ovf_clr,
  input  logic [NUM_TMR-1:0]            gate_clr,
  output logic [NUM_TMR-1:0]            ovf_flags,
  output logic [NUM_TMR-1:0]            gate_flags,
  output logic                          sweeping,
  output logic                          mem_we,
  output logic [$clog2(NUM_TMR)+1:0]    mem_waddr,
  output logic [tpool_pkg::BYTE_W-1:0]  mem_wdata,
  output logic [$clog2(NUM_TMR)+1:0]    mem_raddr,
  input  logic [tpool_pkg::BYTE_W-1:0]  mem_rdata
);
  import tpool_pkg::*;

  localparam int ID_W = $clog2(NUM_TMR);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_TMR - 1);
  localparam int BUSY_MAX = 10;

  eng_state_e        state_q, state_d;
  logic [ID_W-1:0]   idx_q, idx_d;
  logic              carry_q, carry_d;
  logic              sweep_q, sweep_d;
  logic              pend_q, pend_d;
  logic              cpend_q, cpend_d;
  logic [ID_W-1:0]   cid_q, cid_d;
  logic              cstart_q, cstart_d;
  logic [CNT_W-1:0]  cinit_q, cinit_d;
  logic [NUM_TMR-1:0] ovf_q, ovf_d, gate_q, gate_d;
  logic [NUM_TMR-1:0] ovf_set, ovf_wipe, gate_set;
  logic              advance;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    carry_d  = carry_q;
    sweep_d  = sweep_q;
    pend_d   = pend_q | tick;
    cpend_d  = cpend_q;
    cid_d    = cid_q;
    cstart_d = cstart_q;
    cinit_d  = cinit_q;
    ovf_set  = '0;
    ovf_wipe = '0;
    gate_set = '0;
    advance  = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = {idx_q, SLOT_CNT_LO};
    mem_wdata = '0;
    mem_raddr = {idx_q, SLOT_CNT_LO};

    if (cmd_valid && !cpend_q) begin
      cpend_d  = 1'b1;
      cid_d    = cmd_sel;
      cstart_d = cmd_start;
      cinit_d  = cmd_init;
    end

    unique case (state_q)
      ST_ARB: begin
        if (cpend_q) begin
          state_d = ST_CMD_0;
        end else if (sweep_q) begin
          state_d = ST_INC_LO;
        end else if (pend_q) begin
          sweep_d = 1'b1;
          idx_d   = '0;
          pend_d  = tick;
          state_d = ST_INC_LO;
        end
      end
      ST_INC_LO: begin
        mem_raddr = {idx_q, SLOT_CNT_LO};
        mem_we    = 1'b1;
        mem_waddr = {idx_q, SLOT_CNT_LO};
        mem_wdata = mem_rdata + 1'b1;
        carry_d   = &mem_rdata;
        state_d   = ST_INC_HI;
      end
      ST_INC_HI: begin
        mem_raddr = {idx_q, SLOT_CNT_HI};
        mem_we    = 1'b1;
        mem_waddr = {idx_q, SLOT_CNT_HI};
        mem_wdata = mem_rdata + {{(BYTE_W-1){1'b0}}, carry_q};
        if (carry_q && (&mem_rdata)) begin
          ovf_set[idx_q] = 1'b1;
          state_d        = ST_RLD_LO;
        end else begin
          advance = 1'b1;
        end
      end
      ST_RLD_LO: begin
        mem_raddr = {idx_q, SLOT_RLD_LO};
        mem_we    = 1'b1;
        mem_waddr = {idx_q, SLOT_CNT_LO};
        mem_wdata = mem_rdata;
        state_d   = ST_RLD_HI;
      end
      ST_RLD_HI: begin
        mem_raddr = {idx_q, SLOT_RLD_HI};
        mem_we    = 1'b1;
        mem_waddr = {idx_q, SLOT_CNT_HI};
        mem_wdata = mem_rdata;
        advance   = 1'b1;
      end
      ST_CMD_0: begin
        mem_we    = 1'b1;
        mem_waddr = {cid_q, SLOT_RLD_LO};
        mem_wdata = cinit_q[BYTE_W-1:0];
        state_d   = ST_CMD_1;
      end
      ST_CMD_1: begin
        mem_we    = 1'b1;
        mem_waddr = {cid_q, SLOT_RLD_HI};
        mem_wdata = cinit_q[CNT_W-1:BYTE_W];
        if (cstart_q) begin
          state_d = ST_CMD_2;
        end else begin
          cpend_d = 1'b0;
          state_d = ST_ARB;
        end
      end
      ST_CMD_2: begin
        mem_we    = 1'b1;
        mem_waddr = {cid_q, SLOT_CNT_LO};
        mem_wdata = cinit_q[BYTE_W-1:0];
        state_d   = ST_CMD_3;
      end
      ST_CMD_3: begin
        mem_we          = 1'b1;
        mem_waddr       = {cid_q, SLOT_CNT_HI};
        mem_wdata       = cinit_q[CNT_W-1:BYTE_W];
        ovf_wipe[cid_q] = 1'b1;
        gate_set[cid_q] = 1'b1;
        cpend_d         = 1'b0;
        state_d         = ST_ARB;
      end
      default: state_d = ST_ARB;
    endcase

    if (advance) begin
      if (idx_q == LAST_ID) sweep_d = 1'b0;
      idx_d   = idx_q + 1'b1;
      state_d = ST_ARB;
    end

    ovf_d  = (ovf_q & ~ovf_clr & ~ovf_wipe) | ovf_set;
    gate_d = (gate_q & ~gate_clr) | gate_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ARB;
      idx_q    <= '0;
      carry_q  <= 1'b0;
      sweep_q  <= 1'b0;
      pend_q   <= 1'b0;
      cpend_q  <= 1'b0;
      cid_q    <= '0;
      cstart_q <= 1'b0;
      cinit_q  <= '0;
      ovf_q    <= '0;
      gate_q   <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      carry_q  <= carry_d;
      sweep_q  <= sweep_d;
      pend_q   <= pend_d;
      cpend_q  <= cpend_d;
      cid_q    <= cid_d;
      cstart_q <= cstart_d;
      cinit_q  <= cinit_d;
      ovf_q    <= ovf_d;
      gate_q   <= gate_d;
    end
  end

  assign cmd_busy   = cpend_q;
  assign ovf_flags  = ovf_q;
  assign gate_flags = gate_q;
  assign sweeping   = sweep_q | pend_q;

  // busy-length counter used only by the bound check below
  logic [3:0] bcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcnt_q <= '0;
    else if (!cpend_q) bcnt_q <= '0;
    else if (bcnt_q != 4'hF) bcnt_q <= bcnt_q + 1'b1;
  end

  // R8: a command is stored within the bounded wait
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= 4'(BUSY_MAX));

  // R3: every sweep starts at the first timer
  p_sweep_from_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_q) |-> (idx_q == '0));

  // R9: a tick is always remembered in the following cycle
  p_tick_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend_q);

  // R9: a second tick never lands on an unconsumed pending one
  p_no_tick_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |-> (state_q == ST_ARB && !sweep_q && !cpend_q));

  // R4: overflow flags only rise out of a high-byte step
  p_ovf_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_q & ~$past(ovf_q))) |-> ($past(state_q) == ST_INC_HI));

  // R6: gate flags only rise out of a start command's last write
  p_gate_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_q & ~$past(gate_q))) |-> ($past(state_q) == ST_CMD_3));

  // R7: the sweep never hands over to a command between a timer's byte steps
  p_cmd_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD_0) |-> ($past(state_q) == ST_ARB));

  // R10: a flag set by the engine survives a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INC_HI && carry_q && (&mem_rdata)) |=> ovf_q[$past(idx_q)]);

endmodule

// File: rtl/tpool_top.sv
module tpool_top #(
  parameter int NUM_TMR = 16,
  parameter int PRE_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pre_wr,
  input  logic [PRE_W-1:0]              pre_period,
  input  logic                          cmd_valid,
  input  logic [$clog2(NUM_TMR)-1:0]    cmd_sel,
  input  logic                          cmd_start,
  input  logic [15:0]                   cmd_init,
  output logic                          cmd_busy,
  input  logic [NUM_TMR-1:0]            ovf_clr,
  input  logic [NUM_TMR-1:0]            gate_clr,
  output logic [NUM_TMR-1:0]            ovf_flags,
  output logic [NUM_TMR-1:0]            gate_flags,
  input  logic [$clog2(NUM_TMR)-1:0]    rd_sel,
  output logic [15:0]                   rd_count,
  output logic                          tick_o,
  output logic                          sweeping
);
  import tpool_pkg::*;

  localparam int ID_W = $clog2(NUM_TMR);
  localparam int AW   = ID_W + 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              tick;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  tpool_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (pre_wr),
    .wr_period (pre_period),
    .tick      (tick)
  );

  tpool_engine #(.NUM_TMR(NUM_TMR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .cmd_valid  (cmd_valid),
    .cmd_sel    (cmd_sel),
    .cmd_start  (cmd_start),
    .cmd_init   (cmd_init),
    .cmd_busy   (cmd_busy),
    .ovf_clr    (ovf_clr),
    .gate_clr   (gate_clr),
    .ovf_flags  (ovf_flags),
    .gate_flags (gate_flags),
    .sweeping   (sweeping),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_raddr  (mem_raddr),
    .mem_rdata  (mem_rdata)
  );

  tpool_store #(.NUM_TMR(NUM_TMR)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (mem_we),
    .waddr      (mem_waddr),
    .wdata      (mem_wdata),
    .eng_raddr  (mem_raddr),
    .eng_rdata  (mem_rdata),
    .host_sel   (rd_sel),
    .host_count (rd_count)
  );

  assign tick_o = tick;

  // R11: the read port shows zero counts straight after reset release
  p_read_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (rd_count == '0));

endmodule

// File: tb/tpool_top_test.sv
`timescale 1ns/1ps
module tpool_top_test;

  localparam int NT = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_wr;
  logic [15:0] pre_period;
  logic        cmd_valid;
  logic [3:0]  cmd_sel;
  logic        cmd_start;
  logic [15:0] cmd_init;
  logic        cmd_busy;
  logic [15:0] ovf_clr, gate_clr, ovf_flags, gate_flags;
  logic [3:0]  rd_sel;
  logic [15:0] rd_count;
  logic        tick_o, sweeping;

  always #5 clk = ~clk;

  tpool_top uut (
    .clk(clk), .rst_n(rst_n), .pre_wr(pre_wr), .pre_period(pre_period),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_start(cmd_start),
    .cmd_init(cmd_init), .cmd_busy(cmd_busy), .ovf_clr(ovf_clr),
    .gate_clr(gate_clr), .ovf_flags(ovf_flags), .gate_flags(gate_flags),
    .rd_sel(rd_sel), .rd_count(rd_count), .tick_o(tick_o), .sweeping(sweeping)
  );

  int n_vec = 0;
  int n_bad = 0;
  int ticks_seen = 0;
  int cyc = 0;
  bit live = 1'b0;

  logic [15:0] m_cnt [NT];
  logic [15:0] m_rld [NT];
  logic [15:0] m_ovf, m_gate;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model_tick();
    for (int i = 0; i < NT; i++) begin
      if (m_cnt[i] == 16'hFFFF) begin
        m_cnt[i] = m_rld[i];
        m_ovf[i] = 1'b1;
      end else begin
        m_cnt[i] = m_cnt[i] + 16'd1;
      end
    end
  endfunction

  always @(negedge clk) begin
    if (live && tick_o) begin
      model_tick();
      ticks_seen = ticks_seen + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NT; i++) begin
      rd_sel = 4'(i);
      #1;
      chk($sformatf("%s R11 count t%0d", tag, i), {16'd0, rd_count}, {16'd0, m_cnt[i]});
    end
    chk({tag, " ovf_flags"}, {16'd0, ovf_flags}, {16'd0, m_ovf});
    chk({tag, " gate_flags"}, {16'd0, gate_flags}, {16'd0, m_gate});
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (sweeping || tick_o || cmd_busy) @(negedge clk);
  endtask

  task automatic set_period(input logic [15:0] p);
    @(negedge clk);
    pre_wr = 1'b1; pre_period = p;
    @(negedge clk);
    pre_wr = 1'b0;
  endtask

  task automatic stop_now();
    pre_wr = 1'b1; pre_period = 16'd0;
    @(negedge clk);
    pre_wr = 1'b0;
  endtask

  task automatic run_ticks(input logic [15:0] p, input int n);
    int start;
    start = ticks_seen;
    set_period(p);
    while (ticks_seen - start < n) @(negedge clk);
    stop_now();
    wait_quiet();
  endtask

  task automatic send_cmd(input logic [3:0] id, input logic [15:0] init,
                          input logic st, output int blen);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = id; cmd_init = init; cmd_start = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    blen = 0;
    while (cmd_busy) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic model_cmd(input logic [3:0] id, input logic [15:0] init, input logic st);
    m_rld[id] = init;
    if (st) begin
      m_cnt[id]  = init;
      m_ovf[id]  = 1'b0;
      m_gate[id] = 1'b1;
    end
  endtask

  task automatic pulse_clr(input logic [15:0] om, input logic [15:0] gm);
    @(negedge clk);
    ovf_clr = om; gate_clr = gm;
    @(negedge clk);
    ovf_clr = '0; gate_clr = '0;
    m_ovf  = m_ovf & ~om;
    m_gate = m_gate & ~gm;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int blen, c1, c2, t0;
    logic [3:0] id;
    logic [15:0] init;
    void'($urandom(32'd2024));
    rst_n = 1'b0; pre_wr = 0; pre_period = 0; cmd_valid = 0; cmd_sel = 0;
    cmd_start = 0; cmd_init = 0; ovf_clr = 0; gate_clr = 0; rd_sel = 0;
    for (int i = 0; i < NT; i++) begin m_cnt[i] = 0; m_rld[i] = 0; end
    m_ovf = 0; m_gate = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R1: reset state, no ticks without a period
    check_all("R1 reset");
    repeat (50) @(negedge clk);
    chk("R1 no tick before period", ticks_seen, 0);

    // R2: tick spacing equals the period; second tick lands mid-sweep (R9)
    set_period(16'd7);
    while (!tick_o) @(negedge clk);
    c1 = cyc;
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    c2 = cyc;
    stop_now();
    wait_quiet();
    chk("R2 tick interval", c2 - c1, 7);
    check_all("R3/R9 after two ticks");
    t0 = ticks_seen;
    repeat (40) @(negedge clk);
    chk("R2 period 0 stops ticks", ticks_seen, t0);

    // R6/R8: start and load-only commands with busy timing
    send_cmd(4'd3, 16'hFFFE, 1'b1, blen);
    model_cmd(4'd3, 16'hFFFE, 1'b1);
    chk("R8 busy length start", blen, 5);
    send_cmd(4'd5, 16'h00FF, 1'b1, blen);
    model_cmd(4'd5, 16'h00FF, 1'b1);
    send_cmd(4'd7, 16'h1234, 1'b0, blen);
    model_cmd(4'd7, 16'h1234, 1'b0);
    chk("R8 busy length load-only", blen, 3);
    check_all("R6 commands");

    // R8: a request during busy is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = 4'd15; cmd_init = 16'h0400; cmd_start = 1'b1;
    @(negedge clk);
    cmd_sel = 4'd9; cmd_init = 16'hABCD;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_quiet();
    model_cmd(4'd15, 16'h0400, 1'b1);
    check_all("R8 ignored while busy");

    // R3/R4: carry into high byte and wrap with reload
    run_ticks(16'd100, 2);
    rd_sel = 4'd5; #1;
    chk("R3 carry 0x00FF+2", {16'd0, rd_count}, 32'h0101);
    rd_sel = 4'd3; #1;
    chk("R4 wrap reload", {16'd0, rd_count}, 32'hFFFE);
    chk("R4 overflow flag t3", {31'd0, ovf_flags[3]}, 32'd1);
    check_all("R4 after wrap");

    // R10/R5: clear flags, timer keeps counting without gate
    pulse_clr(16'h0008, 16'h0008);
    check_all("R10 flags cleared");
    run_ticks(16'd100, 1);
    rd_sel = 4'd3; #1;
    chk("R5 counts with gate low", {16'd0, rd_count}, 32'hFFFF);
    check_all("R5 after tick");

    // R9: short period so a tick waits behind a sweep full of work
    run_ticks(16'd30, 2);
    check_all("R9 pending tick");

    // R7: commands injected at random points inside a sweep
    for (int k = 0; k < 8; k++) begin
      int base, dly;
      id   = 4'($urandom % NT);
      init = 16'($urandom % 16'hFF00);
      dly  = $urandom % 45;
      base = ticks_seen;
      set_period(16'd1000);
      while (ticks_seen == base) @(negedge clk);
      repeat (dly) @(negedge clk);
      send_cmd(id, init, 1'b1, blen);
      n_vec++;
      if (blen > 10) begin
        n_bad++;
        $display("FAIL R8 busy bound: got %0d expected <=10", blen);
      end
      wait_quiet();
      stop_now();
      rd_sel = id; #1;
      n_vec++;
      if (rd_count !== init && rd_count !== init + 16'd1) begin
        n_bad++;
        $display("FAIL R7 target t%0d: got %h expected %h or %h", id, rd_count, init, init + 16'd1);
      end
      model_cmd(id, init, 1'b1);
      m_cnt[id] = rd_count;
      check_all("R7 others untouched");
    end

    // random mix
    for (int k = 0; k < 30; k++) begin
      int op;
      op = $urandom % 4;
      id = 4'($urandom % NT);
      init = ($urandom % 3 == 0) ? 16'(16'hFFF8 + ($urandom % 8)) : 16'($urandom);
      case (op)
        0: begin send_cmd(id, init, 1'b1, blen); model_cmd(id, init, 1'b1); end
        1: begin send_cmd(id, init, 1'b0, blen); model_cmd(id, init, 1'b0); end
        2: run_ticks(16'(60 + $urandom % 40), 1 + $urandom % 3);
        default: pulse_clr(16'($urandom), 16'($urandom));
      endcase
      wait_quiet();
      check_all($sformatf("R3/R4/R6/R10 random %0d", k));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule